// File: doc/BRIEF.md
# Serial Radix-4 Multiplier Unit

This block multiplies an unsigned 8-bit or 16-bit multiplicand by an unsigned 8-bit factor. The multiplicand arrives as 2-bit digits, least significant digit first, one per clock. Each digit consumed yields exactly two product bits one clock later. The factor, the width and the high-byte request are captured with the start pulse. The digit presented in the start cycle is digit 0.

The unit needs no times-3 multiple. A digit of 3 counts as -1 and carries one into the next digit. A digit of 3 plus an incoming carry (an effective 4) counts as 0 and passes the carry on. Only three multiples of the factor are formed: zero, the factor itself and the factor shifted left by one, plus their negation for the -1 case. A 9-bit signed partial sum is added to the selected multiple in an 11-bit adder. Its low two bits leave as output and the rest is shifted right by two.

The low phase emits the low 8 or 16 product bits. When the high byte is requested, a second phase of four cycles follows. It feeds zero digits, applies any pending carry and drains the top 8 bits of the 16-bit or 24-bit product. A flag marks this second phase.

Top module: `serial_mul4`

## Requirements
- R1: While reset is asserted and after it is released, with no start accepted, prodValid, phaseHigh and prodOut are all zero.
- R2: A start in an idle cycle captures factorIn, wideMode and wantHigh, and consumes digitIn as multiplicand bits [1:0]. Each following cycle of the low phase consumes the next 2-bit digit in ascending order.
- R3: Each consumed digit or drain step produces two product bits on prodOut in the next cycle, with prodValid high. Bit pairs come out in ascending order of significance.
- R4: With wideMode=0 the low phase lasts 4 cycles and emits bits [7:0] of (multiplicand[7:0] × factor).
- R5: With wideMode=1 the low phase lasts 8 cycles and emits bits [15:0] of (multiplicand[15:0] × factor).
- R6: With wantHigh=1 four more output cycles follow the low phase directly, with phaseHigh=1. They carry the next 8 product bits, i.e. bits [15:8] (narrow) or [23:16] (wide). At the end the partial sum and the digit carry are both zero.
- R7: With wantHigh=0 prodValid falls right after the low phase and phaseHigh stays 0.
- R8: A start pulse while an operation is in progress is ignored, together with the factor, width and high-byte values presented with it.
- R9: A new start is accepted in the cycle right after the last digit or drain step of the previous operation, so results leave back to back without a gap.
- R10: digitIn is ignored during the high phase.
- R11: Digits of value 3 and chains of them (e.g. 0xFF, 0xFFFF), including a carry that leaves the last multiplicand digit, give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only when idle |
| wideMode | input | 1 | 1: 16-bit multiplicand, 0: 8-bit |
| wantHigh | input | 1 | 1: run the high phase for the top 8 product bits |
| factorIn | input | 8 | Unsigned factor, captured at start |
| digitIn | input | 2 | Multiplicand digit stream, LSB digit first |
| prodOut | output | 2 | Product bit pair |
| prodValid | output | 1 | prodOut carries product bits |
| phaseHigh | output | 1 | Current bit pair belongs to the high phase |

## Verification
Two things can share one clock here. The cycle after the final step of an operation still presents that operation's last product bits, and a new start may consume the first digit of the next operation in the same cycle. The bench provokes this by issuing operations back to back, both with and without the high phase. It judges the result by requiring both reconstructed products to be exact. Inside one operation, the last low-phase digit can leave a pending carry that the first drain cycle must absorb. Operands built from digit 3, such as 0xFF and 0xFFFF, exercise this path, and the full product is compared against a reference multiply.

// File: rtl/mulser_pkg.sv
package mulser_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic step;   // a digit or drain step is processed this cycle
    logic first;  // first step: clear partial sum, use factorIn
    logic feed;   // take digitIn (else a zero digit)
    logic high;   // this step belongs to the high phase
  } mulStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } mulState_t;

endpackage

// File: rtl/mulser_ctrl.sv
module mulser_ctrl
  import mulser_pkg::*;
#(
  parameter int NARROW_DIGITS = 4,
  parameter int WIDE_DIGITS   = 8,
  parameter int HIGH_DIGITS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wideMode,
  input  logic       wantHigh,
  output mulStrobe_t strb
);

  localparam int CNT_W = $clog2(WIDE_DIGITS) + 1;
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_DIGITS - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_DIGITS - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST   = CNT_W'(HIGH_DIGITS - 1);

  mulState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext, curIdx, lowLast;
  logic             wideQ, highQ, accept, wideCur, highCur;

  always_comb begin
    accept  = (state == ST_IDLE) && start;
    wideCur = accept ? wideMode : wideQ;
    highCur = accept ? wantHigh : highQ;
    lowLast = wideCur ? WIDE_LAST : NARROW_LAST;
    curIdx  = accept ? '0 : cnt;

    strb.step  = accept || (state != ST_IDLE);
    strb.first = accept;
    strb.feed  = accept || (state == ST_LOW);
    strb.high  = (state == ST_HIGH);

    stateNext = state;
    cntNext   = cnt;
    if (accept || state == ST_LOW) begin
      if (curIdx == lowLast) begin
        stateNext = highCur ? ST_HIGH : ST_IDLE;
        cntNext   = '0;
      end else begin
        stateNext = ST_LOW;
        cntNext   = curIdx + 1'b1;
      end
    end else if (state == ST_HIGH) begin
      if (cnt == HIGH_LAST) begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end else begin
        cntNext = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wideQ <= 1'b0;
      highQ <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (accept) begin
        wideQ <= wideMode;
        highQ <= wantHigh;
      end
    end
  end

  AST_HIGH_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH) |-> highQ); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |=> (wideQ == $past(wideQ) && highQ == $past(highQ))); // R8

  AST_LOW_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW) |-> (cnt <= (wideQ ? WIDE_LAST : NARROW_LAST))); // R5

  AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && cnt == (wideQ ? WIDE_LAST : NARROW_LAST) && highQ) |=> (state == ST_HIGH)); // R6

endmodule

// File: rtl/mulser_dp.sv
module mulser_dp
  import mulser_pkg::*;
#(
  parameter int FACTOR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  mulStrobe_t          strb,
  input  logic [FACTOR_W-1:0] factorIn,
  input  logic [1:0]          digitIn,
  output logic [1:0]          prodOut,
  output logic                prodValid,
  output logic                phaseHigh
);

  localparam int ACC_W = FACTOR_W + 1;  // partial sum with sign
  localparam int SUM_W = FACTOR_W + 3;  // adder width

  logic [FACTOR_W-1:0] factorQ, factorCur;
  logic [ACC_W-1:0]    accQ, accCur;
  logic                carryQ, carryCur, carryNext;
  logic [1:0]          digitCur;
  logic [2:0]          effDigit;
  logic [SUM_W-1:0]    fExt, term, sum;

  always_comb begin
    factorCur = strb.first ? factorIn : factorQ;
    accCur    = strb.first ? '0 : accQ;
    carryCur  = strb.first ? 1'b0 : carryQ;
    digitCur  = strb.feed ? digitIn : 2'b00;
    effDigit  = {1'b0, digitCur} + {2'b00, carryCur};
    fExt      = {{(SUM_W-FACTOR_W){1'b0}}, factorCur};

    // Recoded multiple: 3 -> -1 with carry, 4 -> 0 with carry
    case (effDigit)
      3'd1:    term = fExt;
      3'd2:    term = fExt << 1;
      3'd3:    term = ~fExt + 1'b1;
      default: term = '0;
    endcase
    carryNext = (effDigit >= 3'd3);

    sum = {{(SUM_W-ACC_W){accCur[ACC_W-1]}}, accCur} + term;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      factorQ   <= '0;
      accQ      <= '0;
      carryQ    <= 1'b0;
      prodOut   <= 2'b00;
      prodValid <= 1'b0;
      phaseHigh <= 1'b0;
    end else begin
      prodValid <= strb.step;
      phaseHigh <= strb.step && strb.high;
      if (strb.step) begin
        factorQ <= factorCur;
        accQ    <= sum[SUM_W-1:2];
        carryQ  <= carryNext;
        prodOut <= sum[1:0];
      end else begin
        prodOut <= 2'b00;
      end
    end
  end

  AST_HIGH_IGNORES_DIGITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.high |-> !strb.feed); // R10

  AST_HIGH_IS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    phaseHigh |-> prodValid); // R6

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (phaseHigh && !strb.high) |-> (accQ == '0 && !carryQ)); // R6

  AST_START_GIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    strb.first |=> prodValid); // R3

endmodule

// File: rtl/serial_mul4.sv
module serial_mul4
  import mulser_pkg::*;
#(
  parameter int FACTOR_W      = 8,
  parameter int NARROW_DIGITS = 4,
  parameter int WIDE_DIGITS   = 8,
  parameter int HIGH_DIGITS   = FACTOR_W / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                wideMode,
  input  logic                wantHigh,
  input  logic [FACTOR_W-1:0] factorIn,
  input  logic [1:0]          digitIn,
  output logic [1:0]          prodOut,
  output logic                prodValid,
  output logic                phaseHigh
);

  mulStrobe_t strb;

  mulser_ctrl #(
    .NARROW_DIGITS(NARROW_DIGITS),
    .WIDE_DIGITS  (WIDE_DIGITS),
    .HIGH_DIGITS  (HIGH_DIGITS)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .wideMode(wideMode),
    .wantHigh(wantHigh),
    .strb    (strb)
  );

  mulser_dp #(
    .FACTOR_W(FACTOR_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .factorIn (factorIn),
    .digitIn  (digitIn),
    .prodOut  (prodOut),
    .prodValid(prodValid),
    .phaseHigh(phaseHigh)
  );

endmodule

// File: tb/test_serial_mul4.sv
module test_serial_mul4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0, wideMode = 1'b0, wantHigh = 1'b0;
  logic [7:0] factorIn = '0;
  logic [1:0] digitIn = '0;
  logic [1:0] prodOut;
  logic       prodValid, phaseHigh;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_mul4 i_serial_mul4 (
    .clk(clk), .rstN(rstN), .start(start), .wideMode(wideMode), .wantHigh(wantHigh),
    .factorIn(factorIn), .digitIn(digitIn), .prodOut(prodOut), .prodValid(prodValid),
    .phaseHigh(phaseHigh)
  );

  // Fields: [25] wide, [24] high, [23:16] factor, [15:0] multiplicand
  localparam int NVEC = 14;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'hFF, 16'h00FF},
    {1'b1, 1'b1, 8'hFF, 16'hFFFF},
    {1'b0, 1'b1, 8'h00, 16'h00FF},
    {1'b1, 1'b1, 8'hFF, 16'h0000},
    {1'b0, 1'b1, 8'h03, 16'h00C0},
    {1'b1, 1'b1, 8'hC0, 16'h0303},
    {1'b0, 1'b0, 8'hFF, 16'h00FF},
    {1'b1, 1'b0, 8'hFF, 16'hFFFF},
    {1'b0, 1'b1, 8'h01, 16'h0001},
    {1'b1, 1'b1, 8'h80, 16'h8000},
    {1'b0, 1'b1, 8'hAB, 16'h12CD},
    {1'b1, 1'b1, 8'h03, 16'hFFFF},
    {1'b1, 1'b0, 8'hC0, 16'hC0C0},
    {1'b0, 1'b1, 8'h55, 16'h00FC}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called right after a negedge; returns at the negedge showing the last result.
  task automatic runOp(input bit w, input bit h, input logic [7:0] f, input logic [15:0] m,
                       input bit poke, input string tag);
    int nLow = w ? 8 : 4;
    int nTot = nLow + (h ? 4 : 0);
    logic [23:0] got = '0;
    logic [23:0] exp;
    logic [23:0] mask;
    bit flagsOk = 1;
    exp  = (w ? {8'h00, m} : {16'h0000, m[7:0]}) * {16'h0000, f};
    mask = (24'h1 << (2 * nTot)) - 24'h1;
    if (nTot == 12) mask = 24'hFFFFFF;
    exp  = exp & mask;
    for (int j = 0; j <= nTot; j++) begin
      if (j > 0) begin
        if (!prodValid || (phaseHigh != ((j - 1) >= nLow))) flagsOk = 0;
        got[2*(j-1) +: 2] = prodOut;
      end
      if (j == 0) begin
        start = 1; wideMode = w; wantHigh = h; factorIn = f; digitIn = m[1:0];
      end else if (j < nTot) begin
        start = poke && (j == 1);
        if (poke) begin wideMode = ~w; wantHigh = ~h; factorIn = ~f; end
        digitIn = (j < nLow) ? m[2*j +: 2] : 2'($urandom);  // R10: junk in high phase
      end else begin
        start = 0;
      end
      if (j < nTot) @(negedge clk);
    end
    check(flagsOk && got == exp, tag, {40'h0, got}, {40'h0, exp});
  endtask

  task automatic idleCheck(input string tag);
    @(negedge clk);
    start = 0;
    check(!prodValid && !phaseHigh, tag, {62'h0, prodValid, phaseHigh}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and after release
    check(!prodValid && !phaseHigh && prodOut == 2'b00, "R1 in reset",
          {61'h0, prodValid, prodOut}, 64'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!prodValid && !phaseHigh && prodOut == 2'b00, "R1 after reset",
          {61'h0, prodValid, prodOut}, 64'h0);

    // Table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:0], 0,
            VEC[i][25] ? "R5/R6/R11 table" : "R4/R6/R11 table");
      idleCheck("R7 idle after op");
    end

    // Random operands, R2 R3
    for (int i = 0; i < 40; i++) begin
      runOp(1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), 0, "R3 random");
      idleCheck("R7 idle after random");
    end

    // R8: start pokes during busy, with flipped config
    runOp(1, 1, 8'hFF, 16'hFFFF, 1, "R8 busy start wide");
    idleCheck("R8 idle");
    runOp(0, 0, 8'hC0, 16'h0003, 1, "R8 busy start narrow");
    idleCheck("R8 idle narrow");

    // R9: back to back, carry pending at the seam
    runOp(0, 1, 8'hFF, 16'h00FF, 0, "R9 first");
    runOp(1, 0, 8'h03, 16'hFFFF, 0, "R9 second");
    runOp(0, 0, 8'hFF, 16'h00FF, 0, "R9 third");
    runOp(1, 1, 8'hFF, 16'hFFFF, 0, "R9 fourth");
    idleCheck("R9 idle");

    // R1: reset mid-operation
    start = 1; wideMode = 1; wantHigh = 1; factorIn = 8'h77; digitIn = 2'b11;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!prodValid && !phaseHigh, "R1 reset mid-op", {63'h0, prodValid}, 64'h0);
    rstN = 1'b1;
    idleCheck("R1 idle after reset");
    runOp(0, 1, 8'h03, 16'h00C0, 0, "R1 op after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule